// File: doc/BRIEF.md
# Two-Path Channel Tap Extractor

This block watches the estimated channel impulse response as it leaves a correlator during a channel-estimation or pilot field. Across the field it keeps the two strongest taps, each with its position in the field and its full complex value. When the field closes it publishes three things for a one-tap interference canceller: the main-path gain, the second-path gain, and the delay of the second path behind the main one. It also publishes a reciprocal of the main-path power, taken from a coarse lookup table, which the equalizer uses in place of a divider.

Taps are ranked by a cheap power estimate. Only the top nine bits of each 18-bit component are squared and summed, and the sum is cut to 15 bits. The delay is only meaningful inside the zero-correlation zone that follows the peak. A second path that lies before the main one, or more than 128 samples after it, is therefore reported as absent. Between fields the block is idle and does nothing with its inputs. Its published registers hold steady, so the equalizer always sees one consistent set of coefficients.

Top module: `chx_path_extractor`

## Requirements
- R1: After reset, busy and done are 0 and every published output (gains, delay, reciprocal) is 0.
- R2: A high fld_start sets busy in the next cycle, and the tap index restarts at 0 for the first sample accepted after it. A sample is accepted only when busy is 1, smp_vld is 1, and neither strobe is high in that cycle. A high fld_end while busy clears busy and raises done for exactly one cycle after that edge. A high fld_end while idle changes nothing.
- R3: The rank power of a sample is computed as follows. Take s9 = bits [17:9] of each component as a signed 9-bit value, compute re9*re9 + im9*im9, and shift the sum right by 3. The result is a 15-bit value, and taps are ranked by it alone.
- R4: A tap whose power is strictly above the main tap's power becomes the main tap, and the old main tap moves to second place. A tap that only beats the second tap, or that arrives while second place is empty, replaces the second tap. On equal power the earlier tap keeps its place.
- R5: The published main gain is the full 18-bit complex value of the main tap, or 0 when the field had no accepted sample.
- R6: The delay is the second tap's index minus the main tap's index. When that value lies in 1..128, it is published together with the second tap's full value. Otherwise the delay and the second gain are both published as 0; this also covers the case where no second tap exists.
- R7: The reciprocal output is read from a 64-entry table addressed by power bits [14:9] of the main tap. Entry a holds min(8191, floor(4194304 / (512*a + 256))).
- R8: The published outputs change only on the edge that raises done and are stable in every other cycle.
- R9: Each field starts with no stored taps, so results from an earlier field never reach a later field's outputs.
- R10: A fld_start while busy throws away the partial field and starts a new one from index 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fld_start | input | 1 | Estimation field begins (one-cycle strobe) |
| fld_end | input | 1 | Estimation field closes (one-cycle strobe) |
| smp_vld | input | 1 | Correlator sample valid |
| smp_re | input | 18 | Correlator sample, real part, signed |
| smp_im | input | 18 | Correlator sample, imaginary part, signed |
| busy | output | 1 | Field scan in progress |
| done | output | 1 | One-cycle pulse when new results are published |
| main_re | output | 18 | Main-path gain, real |
| main_im | output | 18 | Main-path gain, imaginary |
| sec_re | output | 18 | Second-path gain, real (0 if out of zone) |
| sec_im | output | 18 | Second-path gain, imaginary (0 if out of zone) |
| sec_dly | output | 8 | Second-path delay in samples, 0..128 |
| inv_pwr | output | 13 | Reciprocal of main-path power |

## Verification
The assertions assume that a field never holds more accepted samples than the tap index can count, which is 512. The stimulus keeps every field to at most 300 samples. They also assume that the strobes are single-cycle pulses. The bench only ever raises each strobe for one cycle, and every field is closed by fld_end before the next check. Samples that should be ignored are still driven with valid data: during idle time, during gaps where smp_vld is low, and on the strobe cycles. This lets the results show that those samples never reach the ranking.

// File: rtl/chx_pkg.sv
package chx_pkg;
  localparam int SAMP_W  = 18;
  localparam int RANK_W  = 9;
  localparam int PWR_W   = 15;
  localparam int PWR_SH  = 2 * RANK_W - PWR_W;
  localparam int LUT_AW  = 6;
  localparam int INV_W   = 13;
  localparam int NUM_SH  = 22;
  localparam int IDX_W   = 9;

  typedef logic signed [SAMP_W-1:0] samp_t;
  typedef logic [PWR_W-1:0]         pwr_t;

  typedef struct packed {
    logic             vld;
    logic [IDX_W-1:0] idx;
    pwr_t             pwr;
    samp_t            re;
    samp_t            im;
  } tap_t;

  // Coarse power from the upper RANK_W bits of each component.
  function automatic pwr_t rank_power(samp_t re, samp_t im);
    logic signed [RANK_W-1:0]   r_hi;
    logic signed [RANK_W-1:0]   i_hi;
    logic signed [2*RANK_W:0]   acc;
    r_hi = re[SAMP_W-1 -: RANK_W];
    i_hi = im[SAMP_W-1 -: RANK_W];
    acc  = r_hi * r_hi + i_hi * i_hi;
    return PWR_W'(acc >>> PWR_SH);
  endfunction

  // One reciprocal table entry; the divisor is the midpoint of the address bin.
  function automatic int recip_entry(int a, int step, int num_sh, int out_w);
    longint den;
    longint quo;
    longint top;
    den = longint'(a) * step + step / 2;
    quo = (64'sd1 <<< num_sh) / den;
    top = (64'sd1 <<< out_w) - 1;
    return int'((quo > top) ? top : quo);
  endfunction
endpackage

// File: rtl/chx_tap_power.sv
module chx_tap_power
  import chx_pkg::*;
(
  input  samp_t smp_re,
  input  samp_t smp_im,
  output pwr_t  smp_pwr
);
  assign smp_pwr = rank_power(smp_re, smp_im);
endmodule

// File: rtl/chx_recip_lut.sv
module chx_recip_lut
  import chx_pkg::*;
#(
  parameter int AW    = LUT_AW,
  parameter int OW    = INV_W,
  parameter int PW    = PWR_W,
  parameter int NSH   = NUM_SH
) (
  input  logic [AW-1:0] addr,
  output logic [OW-1:0] inv
);
  localparam int DEPTH = 1 << AW;
  localparam int STEP  = 1 << (PW - AW);

  logic [OW-1:0] tbl [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_ent
    assign tbl[a] = OW'(recip_entry(a, STEP, NSH, OW));
  end

  assign inv = tbl[addr];
endmodule

// File: rtl/chx_top2_tracker.sv
module chx_top2_tracker
  import chx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clear,
  input  logic  accept,
  input  samp_t smp_re,
  input  samp_t smp_im,
  input  pwr_t  smp_pwr,
  output tap_t  first,
  output tap_t  second,
  output logic  take_main,
  output logic  take_sec
);
  logic [IDX_W-1:0] idx_q;
  logic             beats_first;
  logic             beats_second;
  tap_t             cand;

  always_comb begin
    cand.vld = 1'b1;
    cand.idx = idx_q;
    cand.pwr = smp_pwr;
    cand.re  = smp_re;
    cand.im  = smp_im;
  end

  // Strict compare: an equal-power later tap never displaces an earlier one.
  assign beats_first  = !first.vld  || (smp_pwr > first.pwr);
  assign beats_second = !second.vld || (smp_pwr > second.pwr);
  assign take_main    = accept && beats_first;
  assign take_sec     = accept && !beats_first && beats_second;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      idx_q  <= '0;
      first  <= '0;
      second <= '0;
    end else begin
      if (accept) idx_q <= idx_q + 1'b1;
      if (take_main) begin
        first  <= cand;
        second <= first;
      end else if (take_sec) begin
        second <= cand;
      end
    end
  end
endmodule

// File: rtl/chx_path_extractor.sv
module chx_path_extractor
  import chx_pkg::*;
#(
  parameter int MAX_DLY = 128,
  parameter int DLY_W   = $clog2(MAX_DLY + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fld_start,
  input  logic                     fld_end,
  input  logic                     smp_vld,
  input  logic signed [SAMP_W-1:0] smp_re,
  input  logic signed [SAMP_W-1:0] smp_im,
  output logic                     busy,
  output logic                     done,
  output logic signed [SAMP_W-1:0] main_re,
  output logic signed [SAMP_W-1:0] main_im,
  output logic signed [SAMP_W-1:0] sec_re,
  output logic signed [SAMP_W-1:0] sec_im,
  output logic [DLY_W-1:0]         sec_dly,
  output logic [INV_W-1:0]         inv_pwr
);
  localparam int REL_W = IDX_W + 1;

  // Named internal events (observed by the bound checker).
  logic accept;
  logic pub_evt;
  logic take_main;
  logic take_sec;
  logic sec_ok;

  pwr_t                    smp_pwr;
  tap_t                    first;
  tap_t                    second;
  logic signed [REL_W-1:0] rel_dly;
  logic [INV_W-1:0]        inv_lut;

  assign accept  = busy && smp_vld && !fld_start && !fld_end;
  assign pub_evt = busy && fld_end && !fld_start;

  chx_tap_power u_pwr (
    .smp_re (smp_re),
    .smp_im (smp_im),
    .smp_pwr(smp_pwr)
  );

  chx_top2_tracker u_trk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (fld_start),
    .accept   (accept),
    .smp_re   (smp_re),
    .smp_im   (smp_im),
    .smp_pwr  (smp_pwr),
    .first    (first),
    .second   (second),
    .take_main(take_main),
    .take_sec (take_sec)
  );

  chx_recip_lut u_lut (
    .addr(first.pwr[PWR_W-1 -: LUT_AW]),
    .inv (inv_lut)
  );

  assign rel_dly = $signed({1'b0, second.idx}) - $signed({1'b0, first.idx});
  assign sec_ok  = second.vld && (rel_dly > 0) && (rel_dly <= REL_W'(MAX_DLY));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= pub_evt;
      if (fld_start)    busy <= 1'b1;
      else if (pub_evt) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      main_re <= '0;
      main_im <= '0;
      sec_re  <= '0;
      sec_im  <= '0;
      sec_dly <= '0;
      inv_pwr <= '0;
    end else if (pub_evt) begin
      main_re <= first.re;
      main_im <= first.im;
      sec_re  <= sec_ok ? second.re : '0;
      sec_im  <= sec_ok ? second.im : '0;
      sec_dly <= sec_ok ? DLY_W'(rel_dly) : '0;
      inv_pwr <= inv_lut;
    end
  end
endmodule

// File: rtl/chx_path_extractor_chk.sv
module chx_path_extractor_chk #(
  parameter int MAX_DLY = 128,
  parameter int DLY_W   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               done,
  input logic               take_main,
  input logic               take_sec,
  input logic signed [17:0] main_re,
  input logic signed [17:0] main_im,
  input logic signed [17:0] sec_re,
  input logic signed [17:0] sec_im,
  input logic [DLY_W-1:0]   sec_dly,
  input logic [12:0]        inv_pwr
);
  a_r2_idle_no_rank: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(take_main || take_sec));

  a_r2_done_ends_scan: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));

  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_dly_bound: assert property (@(posedge clk) disable iff (!rst_n)
    sec_dly <= DLY_W'(MAX_DLY));

  a_r6_zero_gain: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_dly == '0) |-> (sec_re == '0 && sec_im == '0));

  a_r7_inv_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (inv_pwr != '0));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({main_re, main_im, sec_re, sec_im, sec_dly, inv_pwr}));
endmodule

bind chx_path_extractor chx_path_extractor_chk #(
  .MAX_DLY(MAX_DLY),
  .DLY_W  (DLY_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .take_main(take_main),
  .take_sec (take_sec),
  .main_re  (main_re),
  .main_im  (main_im),
  .sec_re   (sec_re),
  .sec_im   (sec_im),
  .sec_dly  (sec_dly),
  .inv_pwr  (inv_pwr)
);

// File: tb/chx_path_extractor_test.sv
module chx_path_extractor_test;
  logic clk = 1'b0;
  logic rst_n, fld_start, fld_end, smp_vld;
  logic signed [17:0] smp_re, smp_im;
  logic busy, done;
  logic signed [17:0] main_re, main_im, sec_re, sec_im;
  logic [7:0]  sec_dly;
  logic [12:0] inv_pwr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic signed [17:0] fre [512];
  logic signed [17:0] fim [512];
  int e_mre, e_mim, e_sre, e_sim, e_dly, e_inv;

  always #5 clk = ~clk;

  chx_path_extractor uut (
    .clk(clk), .rst_n(rst_n), .fld_start(fld_start), .fld_end(fld_end),
    .smp_vld(smp_vld), .smp_re(smp_re), .smp_im(smp_im),
    .busy(busy), .done(done), .main_re(main_re), .main_im(main_im),
    .sec_re(sec_re), .sec_im(sec_im), .sec_dly(sec_dly), .inv_pwr(inv_pwr)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // R3: integer restatement of the coarse power.
  function automatic int pw(logic signed [17:0] re, logic signed [17:0] im);
    int r, i;
    r = int'(re) >>> 9;
    i = int'(im) >>> 9;
    return (r * r + i * i) / 8;
  endfunction

  // R7: reciprocal from the main-path power.
  function automatic int recip(int p);
    int q;
    q = 4194304 / ((p / 512) * 512 + 256);
    return (q > 8191) ? 8191 : q;
  endfunction

  // Expected results: main = earliest tap at the peak power; second = earliest
  // tap at the peak power among the rest (R4, R5, R6, R7).
  task automatic model(input int n);
    int bm, bs, pm, ps, d;
    bm = -1; bs = -1; pm = -1; ps = -1;
    for (int i = 0; i < n; i++) if (pw(fre[i], fim[i]) > pm) begin pm = pw(fre[i], fim[i]); bm = i; end
    for (int i = 0; i < n; i++) if (i != bm && pw(fre[i], fim[i]) > ps) begin ps = pw(fre[i], fim[i]); bs = i; end
    e_mre = (bm < 0) ? 0 : int'(fre[bm]);
    e_mim = (bm < 0) ? 0 : int'(fim[bm]);
    e_inv = recip((bm < 0) ? 0 : pm);
    d = bs - bm;
    if (bs >= 0 && d >= 1 && d <= 128) begin
      e_sre = int'(fre[bs]); e_sim = int'(fim[bs]); e_dly = d;
    end else begin
      e_sre = 0; e_sim = 0; e_dly = 0;
    end
  endtask

  task automatic fill_noise(input int n, input int amp);
    for (int i = 0; i < n; i++) begin
      fre[i] = 18'($urandom_range(0, 2 * amp) - amp);
      fim[i] = 18'($urandom_range(0, 2 * amp) - amp);
    end
  endtask

  task automatic feed(input int n, input int gap_pct);
    for (int i = 0; i < n; i++) begin
      while ($urandom_range(0, 99) < gap_pct) begin
        smp_vld = 1'b0; smp_re = 18'sh1FFFF; smp_im = 18'sh1FFFF;
        @(negedge clk);
      end
      smp_vld = 1'b1; smp_re = fre[i]; smp_im = fim[i];
      @(negedge clk);
    end
  endtask

  // Drives one complete field; a strong junk sample rides on the end strobe (R2).
  task automatic run_field(input int n, input int gap_pct);
    smp_vld = 1'b0; fld_start = 1'b1;
    @(negedge clk);
    fld_start = 1'b0;
    feed(n, gap_pct);
    smp_vld = 1'b1; smp_re = 18'sh1FFFF; smp_im = -18'sh1FFFF; fld_end = 1'b1;
    @(negedge clk);
    fld_end = 1'b0; smp_vld = 1'b0;
  endtask

  task automatic check_pub(input string req);
    chk("R2", {req, " done"}, done, 1);
    chk("R2", {req, " busy"}, busy, 0);
    chk("R5", {req, " main_re"}, main_re, e_mre);
    chk("R5", {req, " main_im"}, main_im, e_mim);
    chk("R6", {req, " sec_re"}, sec_re, e_sre);
    chk("R6", {req, " sec_im"}, sec_im, e_sim);
    chk("R6", {req, " sec_dly"}, sec_dly, e_dly);
    chk("R7", {req, " inv_pwr"}, inv_pwr, e_inv);
    @(negedge clk);
    chk("R2", {req, " done single"}, done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; fld_start = 1'b0; fld_end = 1'b0; smp_vld = 1'b0;
    smp_re = '0; smp_im = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "main_re", main_re, 0);
    chk("R1", "sec_dly", sec_dly, 0);
    chk("R1", "inv_pwr", inv_pwr, 0);

    // R2: idle samples and end strobe have no effect
    smp_vld = 1'b1; smp_re = 18'sh1F000; smp_im = 18'sh0F000; fld_end = 1'b1;
    @(negedge clk);
    fld_end = 1'b0;
    repeat (3) @(negedge clk);
    smp_vld = 1'b0;
    chk("R2", "idle done", done, 0);
    chk("R2", "idle busy", busy, 0);
    chk("R2", "idle main_re", main_re, 0);

    // Directed two-peak field, delay 30
    fill_noise(64, 1500);
    fre[10] = 18'sd90000;  fim[10] = -18'sd20000;
    fre[40] = 18'sd30000;  fim[40] = 18'sd25000;
    model(64); run_field(64, 20); check_pub("R4 two-peak");

    // R8: outputs hold while idle
    repeat (5) @(negedge clk);
    chk("R8", "hold main_re", main_re, e_mre);
    chk("R8", "hold sec_dly", sec_dly, e_dly);

    // R6: delay of exactly 128 is kept
    fill_noise(200, 1000);
    fre[5] = 18'sd100000; fre[133] = 18'sd40000;
    model(200); run_field(200, 0); check_pub("R6 dly128");
    chk("R6", "dly128 value", sec_dly, 128);

    // R6: delay of 129 is dropped
    fill_noise(200, 1000);
    fre[5] = 18'sd100000; fre[134] = 18'sd40000;
    model(200); run_field(200, 0); check_pub("R6 dly129");
    chk("R6", "dly129 value", sec_dly, 0);

    // R6: second path before main path is dropped
    fill_noise(80, 1000);
    fre[12] = 18'sd40000; fre[50] = -18'sd100000;
    model(80); run_field(80, 10); check_pub("R6 negative");
    chk("R6", "negative sec_re", sec_re, 0);

    // R3, R4: equal coarse power keeps the earlier tap as main
    fill_noise(40, 1000);
    fre[7] = 18'sh10000; fre[20] = 18'sh101FF;
    model(40); run_field(40, 0); check_pub("R3 tie");
    chk("R4", "tie main_re", main_re, 18'sh10000);
    chk("R4", "tie sec_dly", sec_dly, 13);

    // R4: later stronger tap demotes old main
    fill_noise(50, 1000);
    fre[3] = 18'sd60000; fre[30] = 18'sd100000;
    model(50); run_field(50, 0); check_pub("R4 demote");
    chk("R4", "demote main_re", main_re, 18'sd100000);

    // Empty field
    model(0); run_field(0, 0); check_pub("R5 empty");
    chk("R7", "empty inv", inv_pwr, 8191);

    // R10: restart discards partial field
    fill_noise(30, 500);
    fre[4] = 18'sd70000;
    smp_vld = 1'b0; fld_start = 1'b1;
    @(negedge clk);
    fld_start = 1'b0;
    smp_vld = 1'b1; smp_re = 18'sd130000; smp_im = 18'sd130000;
    repeat (4) @(negedge clk);
    model(30); run_field(30, 0); check_pub("R10 restart");

    // R9: random fields
    for (int f = 0; f < 25; f++) begin
      int n;
      n = $urandom_range(2, 300);
      if (f % 2 == 0) begin
        for (int i = 0; i < n; i++) begin
          fre[i] = 18'($urandom); fim[i] = 18'($urandom);
        end
      end else begin
        int a, b;
        fill_noise(n, 3000);
        a = $urandom_range(0, n - 1); b = $urandom_range(0, n - 1);
        fre[a] = 18'($urandom_range(50000, 120000));
        fim[b] = 18'($urandom_range(30000, 90000));
      end
      model(n); run_field(n, 15); check_pub("R9 random");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule